// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Controller

This block collects interrupt causes for a bridge controller and presents them to a host processor. Five single-cycle event strobes, from frame buffering, DMA completion and processor write handling, set sticky bits in a 16-bit status word. Two level inputs from the MAC transmit and receive interrupt lines are mirrored as live bits. A change on the raw link pin is caught as a sticky event.

A 16-bit enable word selects which status bits may drive the single registered, active-high interrupt pin. The processor reaches both words over a small register bus with one address bit. Address 0 is the status word, and reading it clears the sticky bits. Address 1 is the enable word, which can be read and written.

A bit whose enable is off still shows in the status word. Software can therefore poll for events without taking interrupts.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the enable word reads 0x0000, the status word reads 0x0000 (with the link pin low) and irq_o is low.
- R2: Each event strobe sets its own status bit on the clock edge where it is sampled high: buffer-full discard at bit 4, DMA done at bit 6, processor-bound packet at bit 8, processor buffer full at bit 9, processor write complete at bit 10.
- R3: A status read (bus_req_i=1, bus_we_i=0, bus_addr_i=0) returns the current status in the same cycle and clears bits 4, 6, 8, 9, 10 and 14 at the end of that cycle.
- R4: An event strobed in the same cycle as a clearing read is still set after that read.
- R5: A status bit whose enable bit is 0 reads as set but does not raise irq_o.
- R6: irq_o is a register equal to the OR over all bits of (status AND enable); it falls in the cycle after a clearing read that removes every enabled cause.
- R7: Bit 12 follows mac_tx_irq_i and bit 13 follows mac_rx_irq_i, each through two synchronizer flops and the status register (3 cycles of latency); a read does not clear them.
- R8: Bit 14 sets when the synchronized link pin changes in either direction, and stays set until a status read.
- R9: Bits 0-3, 5, 7, 11 and 15 of the status word always read 0, and writes to address 0 change nothing.
- R10: A write to address 1 (bus_we_i=1) loads all 16 enable bits, and a read of address 1 returns them. When the bus is not reading, bus_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = status word, 1 = enable word |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational, 0 when not reading |
| buf_full_evt_i | input | 1 | Strobe: frame discarded, buffer full |
| dma_done_evt_i | input | 1 | Strobe: DMA transfer finished |
| proc_pkt_evt_i | input | 1 | Strobe: processor-bound packet present |
| proc_full_evt_i | input | 1 | Strobe: processor-side buffer full |
| proc_wr_done_evt_i | input | 1 | Strobe: processor write finished |
| mac_tx_irq_i | input | 1 | MAC transmit interrupt level, asynchronous |
| mac_rx_irq_i | input | 1 | MAC receive interrupt level, asynchronous |
| link_i | input | 1 | Raw link status pin, asynchronous |
| irq_o | output | 1 | Interrupt pin, registered, active high |

## Verification
If the sticky state is wrong, the fault shows on the next status read. A lost event or a failed clear makes bus_rdata_o differ from the reference in that same cycle. A bad enable or pin path shows on irq_o one edge after the cause, and the bench compares irq_o every cycle. Errors in synchronizer depth or edge detection move bits 12-14 by a cycle, and the per-cycle comparison catches that at the first mismatched edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_W = 16;
  localparam int N_EVT = 5;
  localparam int N_LVL = 2;
  localparam int SYNC_STAGES = 2;

  localparam int B_MAC_TX = 12;
  localparam int B_MAC_RX = 13;
  localparam int B_LINK   = 14;

  // strobe index -> status bit: buf_full, dma_done, proc_pkt, proc_full, proc_wr_done
  localparam logic [N_EVT-1:0][3:0] EVT_POS = {4'd10, 4'd9, 4'd8, 4'd6, 4'd4};

  localparam logic [IRQ_W-1:0] STICKY_MASK = 16'h4750;
  localparam logic [IRQ_W-1:0] LEVEL_MASK  = 16'h3000;
  localparam logic [IRQ_W-1:0] IMPL_MASK   = STICKY_MASK | LEVEL_MASK;

  typedef enum logic {ADDR_STATUS = 1'b0, ADDR_ENABLE = 1'b1} reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] ff_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    ff_q[s] <= '0;
      else if (s == 0) ff_q[s] <= d_i;
      else            ff_q[s] <= ff_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/irq_status.sv
module irq_status
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_LVL-1:0] lvl_i,
  input  logic             link_s_i,
  input  logic             clr_i,
  output logic [IRQ_W-1:0] status_q_o,
  output logic [IRQ_W-1:0] status_d_o
);
  logic [IRQ_W-1:0] status_q, status_d, set_v, keep_v;
  logic             link_prev_q, link_chg;

  assign link_chg = link_s_i ^ link_prev_q;

  always_comb begin
    set_v = '0;
    for (int i = 0; i < N_EVT; i++) set_v[EVT_POS[i]] = evt_i[i];
    set_v[B_LINK] = link_chg;
  end

  // set wins over a same-cycle clear
  assign keep_v = clr_i ? ~STICKY_MASK : '1;

  always_comb begin
    status_d = ((status_q & keep_v) | set_v) & STICKY_MASK;
    status_d[B_MAC_TX] = lvl_i[0];
    status_d[B_MAC_RX] = lvl_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= '0;
      link_prev_q <= 1'b0;
    end else begin
      status_q    <= status_d;
      link_prev_q <= link_s_i;
    end
  end

  assign status_q_o = status_q;
  assign status_d_o = status_d;

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((status_q & STICKY_MASK & ~$past(set_v)) == '0));
  a_r4_no_lost_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((status_q & $past(set_v)) == $past(set_v)));
  a_r7_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (status_q[B_MAC_RX:B_MAC_TX] == $past(lvl_i)));
  a_r8_link_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_chg |=> status_q[B_LINK]);
endmodule

// File: rtl/irq_enable.sv
module irq_enable
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] en_q_o,
  output logic [IRQ_W-1:0] en_d_o
);
  logic [IRQ_W-1:0] en_q, en_d;

  assign en_d = we_i ? wdata_i : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_q_o = en_q;
  assign en_d_o = en_d;

  a_r10_enable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q));
  a_r10_enable_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (en_q == $past(wdata_i)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [IRQ_W-1:0] bus_wdata_i,
  output logic [IRQ_W-1:0] bus_rdata_o,
  input  logic             buf_full_evt_i,
  input  logic             dma_done_evt_i,
  input  logic             proc_pkt_evt_i,
  input  logic             proc_full_evt_i,
  input  logic             proc_wr_done_evt_i,
  input  logic             mac_tx_irq_i,
  input  logic             mac_rx_irq_i,
  input  logic             link_i,
  output logic             irq_o
);
  logic [IRQ_W-1:0] status_q, status_d, en_q, en_d;
  logic [N_LVL:0]   async_s;
  logic             rd_status, rd_enable, wr_enable, irq_q;

  assign rd_status = bus_req_i & ~bus_we_i & (bus_addr_i == ADDR_STATUS);
  assign rd_enable = bus_req_i & ~bus_we_i & (bus_addr_i == ADDR_ENABLE);
  assign wr_enable = bus_req_i &  bus_we_i & (bus_addr_i == ADDR_ENABLE);

  irq_sync #(.W(N_LVL+1), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({link_i, mac_rx_irq_i, mac_tx_irq_i}),
    .q_o    (async_s)
  );

  irq_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      ({proc_wr_done_evt_i, proc_full_evt_i, proc_pkt_evt_i,
                  dma_done_evt_i, buf_full_evt_i}),
    .lvl_i      (async_s[N_LVL-1:0]),
    .link_s_i   (async_s[N_LVL]),
    .clr_i      (rd_status),
    .status_q_o (status_q),
    .status_d_o (status_d)
  );

  irq_enable u_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_enable),
    .wdata_i (bus_wdata_i),
    .en_q_o  (en_q),
    .en_d_o  (en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_d & en_d);
  end

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_status)      bus_rdata_o = status_q & IMPL_MASK;
    else if (rd_enable) bus_rdata_o = en_q;
  end

  a_r6_irq_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(status_q & en_q));
  a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & en_q) == '0) |-> !irq_o);
  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status |-> ((bus_rdata_o & ~IMPL_MASK) == '0));
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!irq_o && en_q == '0));
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        bf = 0, dd = 0, pp = 0, pf = 0, pw = 0;
  logic        mtx = 0, mrx = 0, link = 0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .buf_full_evt_i(bf), .dma_done_evt_i(dd),
    .proc_pkt_evt_i(pp), .proc_full_evt_i(pf), .proc_wr_done_evt_i(pw),
    .mac_tx_irq_i(mtx), .mac_rx_irq_i(mrx), .link_i(link), .irq_o(irq)
  );

  always #2 clk = ~clk;

  localparam logic [15:0] STK = 16'h4750;

  // behavioural reference
  logic [15:0] m_st = '0, m_en = '0, set_v, n_st, n_en;
  logic        m_irq = 0;
  logic        t1 = 0, t2 = 0, r1 = 0, r2 = 0, l1 = 0, l2 = 0, lp = 0;
  logic [15:0] exp_rd;

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = '0; m_en = '0; m_irq = 0;
      t1 = 0; t2 = 0; r1 = 0; r2 = 0; l1 = 0; l2 = 0; lp = 0;
    end else begin
      set_v = '0;
      set_v[4] = bf; set_v[6] = dd; set_v[8] = pp; set_v[9] = pf; set_v[10] = pw;
      set_v[14] = l2 ^ lp;
      n_st = (req && !we && !addr) ? (m_st & ~STK) : m_st;
      n_st = (n_st | set_v) & STK;
      n_st[12] = t2; n_st[13] = r2;
      n_en = (req && we && addr) ? wd : m_en;
      m_irq = |(n_st & n_en);
      m_st = n_st; m_en = n_en;
      lp = l2; l2 = l1; l1 = link;
      t2 = t1; t1 = mtx; r2 = r1; r1 = mrx;
    end
    #1;
    if (rst_n && !done) begin
      exp_rd = (req && !we) ? (addr ? m_en : m_st) : 16'h0;
      chk({cur_req, " irq"}, {15'h0, irq}, {15'h0, m_irq});
      chk({cur_req, " rdata"}, rdata, exp_rd);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 v = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wd = d;
    @(negedge clk); req = 0; we = 0; wd = '0;
  endtask

  task automatic strobe(input logic [4:0] e);
    @(negedge clk); {pw, pf, pp, dd, bf} = e;
    @(negedge clk); {pw, pf, pp, dd, bf} = '0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    idle(3);
    chk("R1 reset irq", {15'h0, irq}, 16'h0);
    chk("R1 reset rdata", rdata, 16'h0);
    @(negedge clk); rst_n = 1;
    cur_req = "R1";
    rd(1, v); chk("R1 enable", v, 16'h0);
    rd(0, v); chk("R1 status", v, 16'h0);

    cur_req = "R2";
    strobe(5'b00001); rd(0, v); chk("R2 buf_full bit4", v, 16'h0010);
    strobe(5'b11110); rd(0, v); chk("R2 bits 6,8,9,10", v, 16'h0740);
    cur_req = "R3";
    rd(0, v); chk("R3 cleared", v, 16'h0000);

    cur_req = "R5";
    strobe(5'b00001); idle(3);
    chk("R5 masked irq low", {15'h0, irq}, 16'h0);
    rd(0, v); chk("R5 masked visible", v, 16'h0010);

    cur_req = "R10";
    wr(1, 16'hFFFF); rd(1, v); chk("R10 enable all", v, 16'hFFFF);
    wr(1, 16'h0010); rd(1, v); chk("R10 enable bit4", v, 16'h0010);

    cur_req = "R6";
    strobe(5'b00010); idle(2);
    chk("R6 disabled cause", {15'h0, irq}, 16'h0);
    rd(0, v);
    strobe(5'b00001); idle(1);
    chk("R6 irq set", {15'h1 & 15'h0, irq}, 16'h1);
    rd(0, v); chk("R6 read value", v, 16'h0010);
    chk("R6 irq drops after read", {15'h0, irq}, 16'h0);

    cur_req = "R4";
    wr(1, 16'h0040);
    @(negedge clk); req = 1; we = 0; addr = 0; dd = 1;
    @(negedge clk); req = 0; dd = 0;
    chk("R4 irq kept", {15'h0, irq}, 16'h1);
    rd(0, v); chk("R4 event kept", v, 16'h0040);

    cur_req = "R7";
    wr(1, 16'h1000);
    @(negedge clk); mtx = 1;
    idle(2); chk("R7 not yet", {15'h0, irq}, 16'h0);
    idle(1); chk("R7 after 3", {15'h0, irq}, 16'h1);
    rd(0, v); chk("R7 tx bit", v, 16'h1000);
    rd(0, v); chk("R7 not cleared", v, 16'h1000);
    @(negedge clk); mtx = 0; mrx = 1;
    idle(4); chk("R7 irq off", {15'h0, irq}, 16'h0);
    rd(0, v); chk("R7 rx bit", v, 16'h2000);
    @(negedge clk); mrx = 0; idle(4);

    cur_req = "R8";
    wr(1, 16'h0000);
    @(negedge clk); link = 1; idle(5);
    rd(0, v); chk("R8 rise", v, 16'h4000);
    rd(0, v); chk("R8 cleared", v, 16'h0000);
    @(negedge clk); link = 0; idle(5);
    rd(0, v); chk("R8 fall", v, 16'h4000);

    cur_req = "R9";
    wr(0, 16'hFFFF); idle(2);
    rd(0, v); chk("R9 status write ignored", v, 16'h0000);
    rd(1, v); chk("R9 enable untouched", v, 16'h0000);
    wr(1, 16'hFFFF); strobe(5'b11111);
    rd(0, v); chk("R9 reserved zero", v & ~16'h7750, 16'h0000);
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule